// File: doc/BRIEF.md
# GCI Time-Slot Channel Transceiver

This block is the serial-side engine of a frame-synchronous 2B+D line-card port. It runs on the bit clock. It counts bit-clock positions from each 8 kHz frame-start strobe and works out where the channel picked by a 3-bit select falls inside the frame. During that time slot it shifts a 32-bit transmit word onto an open-drain serial line and captures a 32-bit word from the serial input. Each serial data bit lasts two bit-clock periods. Outgoing bits change on the first rising edge of a bit period. Incoming bits are taken on the second falling edge of the period.

A transmit word goes into a one-entry holding register through a valid/ready handshake. It is copied into the active shift word only at a frame start, so the word on the line never changes part-way through a slot. The received word appears on a parallel port with a one-cycle strobe. When the frame strobe arrives somewhere other than the expected frame boundary, the position counter restarts on it, and an interrupted receive slot produces no word.

Top module: `gci_slot_xcvr`

## Requirements
- R1: A rising level on `fs_in` seen at a rising `bclk` edge starts a frame, and that edge is position 0. The frame is `FRAME_CLKS` bit clocks long. With no strobe the position counter wraps from `FRAME_CLKS-1` to 0 on its own.
- R2: Channel n occupies serial data bits 32n to 32n+31, which are bit-clock positions 64n to 64n+63. Data is sent and received most significant bit first.
- R3: In positions 2b and 2b+1 of a slot, the line carries slot bit b. The value is updated on the rising edge that begins position 2b.
- R4: `out_en` is 1 only during the selected channel's slot while enabled. `out_pull_lo` is 1 only when `out_en` is 1 and the current bit is 0. The line is never pulled while `out_en` is 0.
- R5: While `ch_en` is 0 at the rising edge that starts a position, `out_en` and `out_pull_lo` are 0 for that position, even inside the slot.
- R6: `ser_in` is sampled only on the falling edge in the second half of each slot bit, which is the falling edge during odd positions 64n+2b+1. Values at other falling edges and outside the slot are ignored. Sampling does not depend on `ch_en`.
- R7: `rx_valid` is high for exactly one bit clock, in position 64n+64, and `rx_data` then holds the 32 bits of the slot.
- R8: `tx_ready` is 1 while the holding register is empty. A word is accepted on a rising edge where `tx_valid` and `tx_ready` are both 1, and `tx_ready` then stays 0 until the next frame start empties the register.
- R9: The active transmit word changes only at a frame start, and only if the holding register is full at that point. A word written mid-frame does not affect the current frame. With no new word, the previous word is sent again.
- R10: A strobe at any position other than `FRAME_CLKS-1` restarts the count at 0. A receive slot cut short by it yields no `rx_valid`, and the next complete slot yields the clean word.
- R11: After reset, `out_en`, `out_pull_lo` and `rx_valid` are 0, `rx_data` is 0, `tx_ready` is 1, and the active transmit word is all ones, so the line is not pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_in | input | 1 | Frame-start strobe, synchronous to bclk |
| ch_sel | input | CH_BITS | Channel position on the serial bus |
| ch_en | input | 1 | Channel enable for the output |
| tx_data | input | SLOT_BITS | Transmit word offered |
| tx_valid | input | 1 | Transmit word offered this cycle |
| tx_ready | output | 1 | Holding register empty |
| ser_in | input | 1 | Serial receive line |
| out_en | output | 1 | Output driver active (slot and enabled) |
| out_pull_lo | output | 1 | Open-drain pull-down active |
| rx_data | output | SLOT_BITS | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
Every registered output for position k changes on the rising edge that begins position k, so the bench drives inputs 2 ns after a rising edge and samples 7 ns after it, which is after the intervening falling edge. Output-enable and pull-down values are compared against a slot model in the same window. The receive strobe is expected in the window of position 64n+64, one rising edge after the last sampling falling edge. A handshake result is read in the window after the accepting edge, and the effect of a frame start is read in window 0 of the new frame.

// File: rtl/gci_pkg.sv
package gci_pkg;

  // Bit-clock periods per serial data bit.
  localparam int unsigned CLKS_PER_BIT = 2;

  typedef struct packed {
    logic start;  // frame boundary taken this edge
    logic slip;   // boundary arrived away from the expected position
  } frame_evt_t;

  function automatic int unsigned slot_first(input int unsigned ch, input int unsigned bits);
    return ch * bits * CLKS_PER_BIT;
  endfunction

  function automatic logic pos_in_slot(input int unsigned pos, input int unsigned ch,
                                       input int unsigned bits);
    return (pos >= slot_first(ch, bits)) &&
           (pos < slot_first(ch, bits) + bits * CLKS_PER_BIT);
  endfunction

  function automatic int unsigned slot_bit(input int unsigned pos, input int unsigned ch,
                                           input int unsigned bits);
    return (pos - slot_first(ch, bits)) / CLKS_PER_BIT;
  endfunction

  // True in the last bit-clock period of a data bit (second falling edge).
  function automatic logic late_phase(input int unsigned pos, input int unsigned ch,
                                      input int unsigned bits);
    return ((pos - slot_first(ch, bits)) % CLKS_PER_BIT) == CLKS_PER_BIT - 1;
  endfunction

endpackage

// File: rtl/gci_frame_timer.sv
module gci_frame_timer #(
  parameter int unsigned FRAME_CLKS = 512
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fs_in,
  output logic [$clog2(FRAME_CLKS)-1:0] pos,
  output logic [$clog2(FRAME_CLKS)-1:0] pos_nxt,
  output gci_pkg::frame_evt_t           evt
);
  localparam int unsigned PW = $clog2(FRAME_CLKS);

  logic fs_q;
  logic at_end;

  assign at_end = (pos == PW'(FRAME_CLKS - 1));

  always_comb begin
    evt.start = fs_in & ~fs_q;
    evt.slip  = evt.start & ~at_end;
    if (evt.start || at_end) pos_nxt = '0;
    else                     pos_nxt = pos + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      pos  <= PW'(FRAME_CLKS - 1);
    end else begin
      fs_q <= fs_in;
      pos  <= pos_nxt;
    end
  end
endmodule

// File: rtl/gci_tx_path.sv
module gci_tx_path #(
  parameter int unsigned FRAME_CLKS = 512,
  parameter int unsigned SLOT_BITS  = 32,
  parameter int unsigned CH_BITS    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(FRAME_CLKS)-1:0] pos_nxt,
  input  logic                          start,
  input  logic [CH_BITS-1:0]            ch_sel,
  input  logic                          ch_en,
  input  logic [SLOT_BITS-1:0]          tx_data,
  input  logic                          tx_valid,
  output logic                          tx_ready,
  output logic                          out_en,
  output logic                          out_pull_lo,
  output logic [SLOT_BITS-1:0]          cur_word
);
  localparam int unsigned IW = $clog2(SLOT_BITS);

  logic [SLOT_BITS-1:0] hold;
  logic [SLOT_BITS-1:0] word_nxt;
  logic                 hold_full;
  logic                 accept;
  logic                 hit;
  logic                 bit_nxt;
  int unsigned          idx;
  logic [IW-1:0]        ofs;

  assign tx_ready = ~hold_full;
  assign accept   = tx_valid & tx_ready;

  always_comb begin
    word_nxt = (start && hold_full) ? hold : cur_word;
    hit      = gci_pkg::pos_in_slot(32'(pos_nxt), 32'(ch_sel), SLOT_BITS);
    idx      = gci_pkg::slot_bit(32'(pos_nxt), 32'(ch_sel), SLOT_BITS);
    ofs      = IW'(SLOT_BITS - 1 - idx);
    bit_nxt  = 1'b1;
    if (hit) bit_nxt = word_nxt[ofs];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold        <= '0;
      hold_full   <= 1'b0;
      cur_word    <= '1;
      out_en      <= 1'b0;
      out_pull_lo <= 1'b0;
    end else begin
      cur_word <= word_nxt;
      if (accept) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
      end else if (start) begin
        hold_full <= 1'b0;
      end
      out_en      <= hit & ch_en;
      out_pull_lo <= hit & ch_en & ~bit_nxt;
    end
  end
endmodule

// File: rtl/gci_rx_path.sv
module gci_rx_path #(
  parameter int unsigned FRAME_CLKS = 512,
  parameter int unsigned SLOT_BITS  = 32,
  parameter int unsigned CH_BITS    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(FRAME_CLKS)-1:0] pos,
  input  logic [CH_BITS-1:0]            ch_sel,
  input  logic                          ser_in,
  output logic [SLOT_BITS-1:0]          rx_data,
  output logic                          rx_valid,
  output logic                          smp_last
);
  logic [SLOT_BITS-1:0] shreg;
  logic                 smp_now;
  logic                 is_last;

  always_comb begin
    smp_now = gci_pkg::pos_in_slot(32'(pos), 32'(ch_sel), SLOT_BITS) &&
              gci_pkg::late_phase(32'(pos), 32'(ch_sel), SLOT_BITS);
    is_last = smp_now &&
              (gci_pkg::slot_bit(32'(pos), 32'(ch_sel), SLOT_BITS) == SLOT_BITS - 1);
  end

  // Capture on the falling edge that closes each data bit.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      smp_last <= 1'b0;
    end else begin
      if (smp_now) shreg <= {shreg[SLOT_BITS-2:0], ser_in};
      smp_last <= is_last;
    end
  end

  // Hand the completed word over on the next rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= smp_last;
      if (smp_last) rx_data <= shreg;
    end
  end
endmodule

// File: rtl/gci_slot_xcvr.sv
module gci_slot_xcvr #(
  parameter int unsigned FRAME_CLKS = 512,
  parameter int unsigned SLOT_BITS  = 32,
  parameter int unsigned CH_BITS    = 3
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 fs_in,
  input  logic [CH_BITS-1:0]   ch_sel,
  input  logic                 ch_en,
  input  logic [SLOT_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic                 ser_in,
  output logic                 out_en,
  output logic                 out_pull_lo,
  output logic [SLOT_BITS-1:0] rx_data,
  output logic                 rx_valid
);
  localparam int unsigned PW = $clog2(FRAME_CLKS);

  logic [PW-1:0]        pos;
  logic [PW-1:0]        pos_nxt;
  gci_pkg::frame_evt_t  evt;
  logic                 frame_start;
  logic                 frame_slip;
  logic                 smp_last;
  logic [SLOT_BITS-1:0] cur_word;

  assign frame_start = evt.start;
  assign frame_slip  = evt.slip;

  gci_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) timer_i (
    .clk     (bclk),
    .rst_n   (rst_n),
    .fs_in   (fs_in),
    .pos     (pos),
    .pos_nxt (pos_nxt),
    .evt     (evt)
  );

  gci_tx_path #(.FRAME_CLKS(FRAME_CLKS), .SLOT_BITS(SLOT_BITS), .CH_BITS(CH_BITS)) tx_i (
    .clk         (bclk),
    .rst_n       (rst_n),
    .pos_nxt     (pos_nxt),
    .start       (frame_start),
    .ch_sel      (ch_sel),
    .ch_en       (ch_en),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .out_en      (out_en),
    .out_pull_lo (out_pull_lo),
    .cur_word    (cur_word)
  );

  gci_rx_path #(.FRAME_CLKS(FRAME_CLKS), .SLOT_BITS(SLOT_BITS), .CH_BITS(CH_BITS)) rx_i (
    .clk      (bclk),
    .rst_n    (rst_n),
    .pos      (pos),
    .ch_sel   (ch_sel),
    .ser_in   (ser_in),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .smp_last (smp_last)
  );
endmodule

// File: rtl/gci_slot_xcvr_chk.sv
module gci_slot_xcvr_chk #(
  parameter int unsigned FRAME_CLKS = 512,
  parameter int unsigned SLOT_BITS  = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ch_en,
  input logic                          tx_valid,
  input logic                          tx_ready,
  input logic                          out_en,
  input logic                          out_pull_lo,
  input logic                          rx_valid,
  input logic                          frame_start,
  input logic [$clog2(FRAME_CLKS)-1:0] pos,
  input logic [SLOT_BITS-1:0]          cur_word
);
  AST_PULL_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_pull_lo |-> out_en); // R4

  AST_DISABLED_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> !out_en); // R5

  AST_RX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7

  AST_START_ZEROES_POS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pos == '0)); // R1

  AST_FREEWHEEL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == ($clog2(FRAME_CLKS))'(FRAME_CLKS - 1)) |=> (pos == '0)); // R1

  AST_WORD_HELD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_word)); // R9

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R8
endmodule

bind gci_slot_xcvr gci_slot_xcvr_chk #(.FRAME_CLKS(FRAME_CLKS), .SLOT_BITS(SLOT_BITS)) chk_i (
  .clk         (bclk),
  .rst_n       (rst_n),
  .ch_en       (ch_en),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .out_en      (out_en),
  .out_pull_lo (out_pull_lo),
  .rx_valid    (rx_valid),
  .frame_start (frame_start),
  .pos         (pos),
  .cur_word    (cur_word)
);

// File: tb/gci_slot_xcvr_tb_top.sv
module gci_slot_xcvr_tb_top;
  localparam int unsigned F  = 576;
  localparam int unsigned SB = 32;
  localparam int unsigned CB = 3;

  typedef struct packed {
    logic [2:0]  ch;
    logic        en;
    logic [31:0] txw;
    logic [31:0] rxw;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b1, 32'hA5C3_0F96, 32'h1234_5678},
    '{3'd7, 1'b1, 32'h0000_0000, 32'hFFFF_FFFE},
    '{3'd3, 1'b0, 32'h5555_AAAA, 32'h8000_0001},
    '{3'd5, 1'b1, 32'hFFFF_FFFF, 32'hC0DE_1E55},
    '{3'd2, 1'b1, 32'h8000_0001, 32'h0F0F_F0F0},
    '{3'd6, 1'b1, 32'h3C3C_C3C3, 32'hDEAD_BEEF}
  };
  localparam logic [31:0] D0 = 32'h0123_4567;
  localparam logic [31:0] D1 = 32'hFEDC_BA98;
  localparam int unsigned NEVER = F + 10;

  logic          bclk = 1'b0;
  logic          rst_n = 1'b1;
  logic          fs_in = 1'b0;
  logic [CB-1:0] ch_sel = '0;
  logic          ch_en = 1'b0;
  logic [SB-1:0] tx_data = '0;
  logic          tx_valid = 1'b0;
  logic          ser_in = 1'b1;
  logic          tx_ready, out_en, out_pull_lo, rx_valid;
  logic [SB-1:0] rx_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 bclk = ~bclk;

  gci_slot_xcvr #(.FRAME_CLKS(F), .SLOT_BITS(SB), .CH_BITS(CB)) dut_i (
    .bclk(bclk), .rst_n(rst_n), .fs_in(fs_in), .ch_sel(ch_sel), .ch_en(ch_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .ser_in(ser_in),
    .out_en(out_en), .out_pull_lo(out_pull_lo), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive point: 2 ns after a rising edge.
  task automatic drive_pt();
    @(posedge bclk);
    #2;
  endtask

  // One frame; window k runs from drive point k to the sample point 5 ns later.
  task automatic run_frame(input logic [2:0] ch, input bit en, input logic [31:0] exp_tx,
                           input logic [31:0] rxw, input int unsigned stop_at, input bit fs_end,
                           input int unsigned wr_at, input logic [31:0] wr_word,
                           input logic [2:0] nch, input bit nen, input string oe_tag);
    int unsigned base = 64 * ch;
    int unsigned vpos = 64 * ch + 64;
    int oe_err = 0;
    int lo_err = 0;
    int vcnt = 0;
    int vpos_err = 0;
    bit rdy0 = 0;
    bit wr_ok = 0;
    bit rdy_after = 1;
    logic [31:0] got = '0;
    for (int unsigned k = 0; k <= stop_at; k++) begin
      bit in_slot;
      bit exp_oe;
      bit exp_lo;
      int unsigned b;
      drive_pt();
      in_slot  = (k >= base) && (k < base + 64);
      b        = in_slot ? (k - base) / 2 : 0;
      fs_in    = fs_end && (k == stop_at);
      tx_valid = (k == wr_at);
      tx_data  = wr_word;
      if (k == stop_at) begin
        ch_sel = nch;
        ch_en  = nen;
      end
      // Early half of a bit carries the inverse, so a wrong sampling edge shows.
      if (in_slot) ser_in = (k % 2 == 1) ? rxw[31 - b] : ~rxw[31 - b];
      else         ser_in = k[0] ^ k[3];
      #5;
      exp_oe = in_slot && en;
      exp_lo = exp_oe && !exp_tx[31 - b];
      if (out_en !== exp_oe) oe_err++;
      if (out_pull_lo !== exp_lo) lo_err++;
      if (rx_valid === 1'b1) begin
        vcnt++;
        got = rx_data;
        if (k != vpos) vpos_err++;
      end
      if (k == 0) rdy0 = tx_ready;
      if (k == wr_at) wr_ok = tx_ready;
      if (k == wr_at + 1) rdy_after = tx_ready;
    end
    check(oe_err == 0, oe_tag, "out_en mismatching positions", 32'(oe_err), 0);
    check(lo_err == 0, "R3", "out_pull_lo mismatching positions", 32'(lo_err), 0);
    check(rdy0 == 1'b1, "R8", "tx_ready in position 0", 32'(rdy0), 1);
    if (vpos <= stop_at) begin
      check(vcnt == 1 && vpos_err == 0, "R7", "rx_valid pulse count", 32'(vcnt), 1);
      check(got == rxw, "R6", "rx_data word", got, rxw);
    end else begin
      check(vcnt == 0, "R10", "rx_valid after cut slot", 32'(vcnt), 0);
    end
    if (wr_at < stop_at) begin
      check(wr_ok == 1'b1, "R8", "tx_ready when offered", 32'(wr_ok), 1);
      check(rdy_after == 1'b0, "R8", "tx_ready after accept", 32'(rdy_after), 0);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge bclk);
    #7;
    // R11: reset state
    check(out_en == 1'b0, "R11", "out_en in reset", 32'(out_en), 0);
    check(out_pull_lo == 1'b0, "R11", "out_pull_lo in reset", 32'(out_pull_lo), 0);
    check(rx_valid == 1'b0, "R11", "rx_valid in reset", 32'(rx_valid), 0);
    check(rx_data == '0, "R11", "rx_data in reset", rx_data, 0);
    check(tx_ready == 1'b1, "R11", "tx_ready in reset", 32'(tx_ready), 1);
    drive_pt();
    rst_n = 1'b1;
    ch_sel = 3'd0;
    ch_en = 1'b1;
    drive_pt();
    drive_pt();
    #5;
    // R11: with no word written the line must not be pulled in slot 0
    check(out_pull_lo == 1'b0, "R11", "pull with reset word", 32'(out_pull_lo), 0);
    // Prologue: offer the first word, then raise the frame strobe.
    drive_pt();
    tx_valid = 1'b1;
    tx_data  = VEC[0].txw;
    ch_sel   = VEC[0].ch;
    ch_en    = VEC[0].en;
    drive_pt();
    tx_valid = 1'b0;
    fs_in    = 1'b1;

    // Table walk: each row is one full frame, writing the next row's word.
    for (int i = 0; i < NV; i++) begin
      logic [31:0] nw;
      logic [2:0]  nc;
      bit          ne;
      nw = (i == NV - 1) ? D0 : VEC[i + 1].txw;
      nc = (i == NV - 1) ? 3'd3 : VEC[i + 1].ch;
      ne = (i == NV - 1) ? 1'b1 : VEC[i + 1].en;
      run_frame(VEC[i].ch, VEC[i].en, VEC[i].txw, VEC[i].rxw, F - 1, 1'b1, F - 3, nw, nc, ne,
                VEC[i].en ? "R2 R4" : "R5");
    end

    // R9: a word written in position 10 must not reach this frame's slot.
    run_frame(3'd3, 1'b1, D0, 32'h7E81_00FF, F - 1, 1'b1, 10, D1, 3'd3, 1'b1, "R9");
    // R9: that word appears in the next frame; nothing new is written.
    run_frame(3'd3, 1'b1, D1, 32'h2468_ACE0, F - 1, 1'b1, NEVER, '0, 3'd1, 1'b1, "R9");
    // R9: with the holding register empty the previous word repeats.
    run_frame(3'd1, 1'b1, D1, 32'h1357_9BDF, F - 1, 1'b1, NEVER, '0, 3'd1, 1'b1, "R9");
    // R10: strobe in position 91 cuts the slot of channel 1 short.
    run_frame(3'd1, 1'b1, D1, 32'hFFFF_0000, 90, 1'b1, NEVER, '0, 3'd1, 1'b1, "R10");
    // R10: counting restarts at the strobe; the next full slot gives a clean word.
    run_frame(3'd1, 1'b1, D1, 32'h6A6A_9595, F - 1, 1'b0, NEVER, '0, 3'd2, 1'b1, "R10");
    // R1: no strobe; the counter wraps by itself and slot 2 still lines up.
    run_frame(3'd2, 1'b1, D1, 32'h0BAD_F00D, F - 1, 1'b0, NEVER, '0, 3'd2, 1'b1, "R1");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule